// File: doc/BRIEF.md
# Filtered Event Performance Counter Bank

This block holds a grid of event counters for an address-translation unit, arranged as banks of counter slots. Every slot has four pieces of state. An 8-bit event-select code picks one of the incoming event strobes. Three match/mask filters test the requester ID, the process address-space ID (PASID) and the domain ID that travel with each event. A 48-bit count accumulates the events that pass.

Each clock the block sees a one-hot (or empty) vector of event strobes together with the three 16-bit ID tags of the transaction that caused it. A slot adds one to its count when its selected strobe is high and all three of its filters accept the tags. Software reaches every register through a single-cycle word port. The read data is combinational on the address. Software can load the count directly, which lets it reload a saved value before counting resumes.

Top module: `evt_filter_ctr`

## Requirements
- R1: After reset, every select code, every filter field and every count reads zero.
- R2: The count is 48 bits wide and wraps modulo 2^48. Read data bits 63:48 of a count are zero, and written bits above 47 are dropped.
- R3: A write to a count loads wdata[47:0]. A write in the same cycle as a qualifying event takes priority, and that increment is lost.
- R4: The select register holds 8 bits. Code 0 disables the slot. A code k in 1..24 selects strobe evt_i[k-1]. Codes 25..255 never count.
- R5: A filter register holds the match value in bits 15:0, the enable flag in bit 31 and the ignore mask in bits 47:32. All other bits read zero.
- R6: A filter whose enable is clear always matches. An enabled filter matches when ((tag ^ value) & ~mask) == 0. Filter kind 2 tests rid_i, kind 3 tests pasid_i and kind 4 tests domid_i.
- R7: A slot increments by exactly one in a cycle where its selected strobe is high and all three filters match. The new value is readable after that clock edge.
- R8: The register address is {bank[7:5], counter[4:3], kind[2:0]}, where kind 0 is count, 1 is select, 2 to 4 are the filters and 7 is capability. An unimplemented bank, counter or kind reads zero and ignores writes.
- R9: Kind 7 at any bank or counter reads NUM_BANKS in bits 7:0 and CTRS_PER_BANK in bits 15:8, with all other bits zero. Writes to it are ignored.
- R10: Slots are independent. A write or event aimed at one slot leaves every other slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address {bank, counter, kind} |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data for reg_addr_i (combinational) |
| evt_i | input | 24 | Event strobes, at most one high per cycle |
| rid_i | input | 16 | Requester ID tag of the current event |
| pasid_i | input | 16 | PASID tag of the current event |
| domid_i | input | 16 | Domain ID tag of the current event |

## Verification
The assertions assume that at most one event strobe is high in any cycle and that inputs are stable and known at every rising edge after reset. Given those inputs, they check slot 0 for single-step counting, write priority and a frozen count when disabled. The bench drives every input on the falling edge, pulses a single strobe per scenario and never overlaps a register write with an event except in the one test aimed at write priority. The filter tests place tag bits both inside and outside the mask, so that the compare and the ignore logic are each exercised.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int ID_W         = 16;
  localparam int KIND_W       = 3;
  localparam int FLT_VAL_LSB  = 0;
  localparam int FLT_EN_BIT   = 31;
  localparam int FLT_MASK_LSB = 32;
  localparam int NUM_FLT      = 3;

  typedef logic [KIND_W-1:0] reg_kind_t;
  localparam reg_kind_t KIND_COUNT  = 3'd0;
  localparam reg_kind_t KIND_SELECT = 3'd1;
  localparam reg_kind_t KIND_F_RID  = 3'd2;
  localparam reg_kind_t KIND_F_PAS  = 3'd3;
  localparam reg_kind_t KIND_F_DOM  = 3'd4;
  localparam reg_kind_t KIND_CAP    = 3'd7;

  typedef struct packed {
    logic            en;
    logic [ID_W-1:0] mask;
    logic [ID_W-1:0] value;
  } flt_t;
endpackage

// File: rtl/evc_filter.sv
module evc_filter
  import evc_pkg::*;
(
  input  flt_t            cfg_i,
  input  logic [ID_W-1:0] tag_i,
  output logic            match_o
);
  // mask bit set = ignore that tag bit
  assign match_o = !cfg_i.en || (((tag_i ^ cfg_i.value) & ~cfg_i.mask) == '0);
endmodule

// File: rtl/evc_slot.sv
module evc_slot
  import evc_pkg::*;
#(
  parameter int NUM_EVENTS = 24,
  parameter int CNT_W      = 48,
  parameter int SEL_W      = 8,
  parameter int DATA_W     = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  reg_kind_t         kind_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_EVENTS-1:0] evt_i,
  input  logic [ID_W-1:0]   rid_i,
  input  logic [ID_W-1:0]   pasid_i,
  input  logic [ID_W-1:0]   domid_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_q;
  flt_t             flt_q [NUM_FLT];
  logic [ID_W-1:0]  tag   [NUM_FLT];
  logic [NUM_FLT-1:0] match;
  logic             evt_sel;

  assign tag[0] = rid_i;
  assign tag[1] = pasid_i;
  assign tag[2] = domid_i;

  for (genvar g = 0; g < NUM_FLT; g++) begin : g_flt
    evc_filter u_flt (
      .cfg_i  (flt_q[g]),
      .tag_i  (tag[g]),
      .match_o(match[g])
    );
  end

  always_comb begin
    evt_sel = 1'b0;
    for (int k = 1; k <= NUM_EVENTS; k++)
      if (sel_q == SEL_W'(k)) evt_sel = evt_i[k-1];
  end

  assign hit_o = evt_sel && (&match);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= '0;
      for (int g = 0; g < NUM_FLT; g++) flt_q[g] <= '0;
    end else begin
      if (we_i && kind_i == KIND_COUNT) cnt_q <= wdata_i[CNT_W-1:0];
      else if (hit_o)                   cnt_q <= cnt_q + 1'b1;
      if (we_i && kind_i == KIND_SELECT) sel_q <= wdata_i[SEL_W-1:0];
      for (int g = 0; g < NUM_FLT; g++) begin
        if (we_i && kind_i == reg_kind_t'(int'(KIND_F_RID) + g)) begin
          flt_q[g].value <= wdata_i[FLT_VAL_LSB +: ID_W];
          flt_q[g].mask  <= wdata_i[FLT_MASK_LSB +: ID_W];
          flt_q[g].en    <= wdata_i[FLT_EN_BIT];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (kind_i)
      KIND_COUNT:  rdata_o[CNT_W-1:0] = cnt_q;
      KIND_SELECT: rdata_o[SEL_W-1:0] = sel_q;
      KIND_F_RID, KIND_F_PAS, KIND_F_DOM: begin
        for (int g = 0; g < NUM_FLT; g++) begin
          if (kind_i == reg_kind_t'(int'(KIND_F_RID) + g)) begin
            rdata_o[FLT_VAL_LSB +: ID_W]  = flt_q[g].value;
            rdata_o[FLT_MASK_LSB +: ID_W] = flt_q[g].mask;
            rdata_o[FLT_EN_BIT]           = flt_q[g].en;
          end
        end
      end
      default: rdata_o = '0;
    endcase
  end

  assign cnt_o = cnt_q;
  assign sel_o = sel_q;
endmodule

// File: rtl/evt_filter_ctr.sv
module evt_filter_ctr
  import evc_pkg::*;
#(
  parameter int NUM_BANKS     = 2,
  parameter int CTRS_PER_BANK = 4,
  parameter int NUM_EVENTS    = 24,
  parameter int CNT_W         = 48,
  parameter int SEL_W         = 8,
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  input  logic [NUM_EVENTS-1:0] evt_i,
  input  logic [ID_W-1:0]       rid_i,
  input  logic [ID_W-1:0]       pasid_i,
  input  logic [ID_W-1:0]       domid_i
);
  localparam int CTR_AW  = 2;
  localparam int BANK_AW = ADDR_W - KIND_W - CTR_AW;
  localparam int NSLOT   = NUM_BANKS * CTRS_PER_BANK;

  reg_kind_t          kind;
  logic [CTR_AW-1:0]  ctr_sel;
  logic [BANK_AW-1:0] bank_sel;
  logic               slot_ok;
  int                 slot_idx;

  logic [DATA_W-1:0] slot_rd  [NSLOT];
  logic [CNT_W-1:0]  cnt_all  [NSLOT];
  logic [SEL_W-1:0]  sel_all  [NSLOT];
  logic [NSLOT-1:0]  hit_all;

  assign kind     = reg_addr_i[KIND_W-1:0];
  assign ctr_sel  = reg_addr_i[KIND_W +: CTR_AW];
  assign bank_sel = reg_addr_i[ADDR_W-1 -: BANK_AW];
  assign slot_ok  = (int'(bank_sel) < NUM_BANKS) && (int'(ctr_sel) < CTRS_PER_BANK);
  assign slot_idx = int'(bank_sel) * CTRS_PER_BANK + int'(ctr_sel);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar c = 0; c < CTRS_PER_BANK; c++) begin : g_ctr
      localparam int IDX = b * CTRS_PER_BANK + c;
      logic slot_we;
      assign slot_we = reg_we_i && (bank_sel == BANK_AW'(b)) && (ctr_sel == CTR_AW'(c));
      evc_slot #(
        .NUM_EVENTS(NUM_EVENTS), .CNT_W(CNT_W), .SEL_W(SEL_W), .DATA_W(DATA_W)
      ) u_slot (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (slot_we),
        .kind_i (kind),
        .wdata_i(reg_wdata_i),
        .evt_i  (evt_i),
        .rid_i  (rid_i),
        .pasid_i(pasid_i),
        .domid_i(domid_i),
        .rdata_o(slot_rd[IDX]),
        .cnt_o  (cnt_all[IDX]),
        .sel_o  (sel_all[IDX]),
        .hit_o  (hit_all[IDX])
      );
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (kind == KIND_CAP) begin
      reg_rdata_o[7:0]  = 8'(NUM_BANKS);
      reg_rdata_o[15:8] = 8'(CTRS_PER_BANK);
    end else if (slot_ok) begin
      for (int s = 0; s < NSLOT; s++)
        if (s == slot_idx) reg_rdata_o = slot_rd[s];
    end
  end
endmodule

// File: rtl/evc_chk.sv
module evc_chk #(
  parameter int NUM_EVENTS = 24,
  parameter int CNT_W      = 48,
  parameter int SEL_W      = 8,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 64
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  reg_we_i,
  input logic [ADDR_W-1:0]     reg_addr_i,
  input logic [DATA_W-1:0]     reg_wdata_i,
  input logic [DATA_W-1:0]     reg_rdata_o,
  input logic [NUM_EVENTS-1:0] evt_i,
  input logic [CNT_W-1:0]      cnt0_i,
  input logic [SEL_W-1:0]      sel0_i,
  input logic                  hit0_i
);
  logic wr0_cnt;
  assign wr0_cnt = reg_we_i && (reg_addr_i == '0);

  a_r4_evt_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(evt_i));

  a_r3_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr0_cnt |=> cnt0_i == $past(reg_wdata_i[CNT_W-1:0]));

  a_r7_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr0_cnt |=> (cnt0_i == $past(cnt0_i)) || (cnt0_i == $past(cnt0_i) + 1'b1));

  a_r7_hit_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr0_cnt && hit0_i) |=> cnt0_i == $past(cnt0_i) + 1'b1);

  a_r4_off_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr0_cnt && sel0_i == '0) |=> $stable(cnt0_i));

  a_r2_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i[2:0] == 3'd0) |-> (reg_rdata_o[DATA_W-1:CNT_W] == '0));
endmodule

bind evt_filter_ctr evc_chk #(
  .NUM_EVENTS(NUM_EVENTS), .CNT_W(CNT_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .evt_i      (evt_i),
  .cnt0_i     (cnt_all[0]),
  .sel0_i     (sel_all[0]),
  .hit0_i     (hit_all[0])
);

// File: tb/evt_filter_ctr_tb.sv
module evt_filter_ctr_tb;
  localparam int CYCLE = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [23:0] evt = '0;
  logic [15:0] rid = '0, pasid = '0, domid = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CYCLE/2) clk = ~clk;

  evt_filter_ctr u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt),
    .rid_i(rid), .pasid_i(pasid), .domid_i(domid)
  );

  function automatic logic [7:0] ra(int b, int c, int k);
    return {3'(b), 2'(c), 3'(k)};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [63:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [63:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(int i, logic [15:0] r, logic [15:0] p, logic [15:0] dm);
    @(negedge clk); evt = 24'(1) << i; rid = r; pasid = p; domid = dm;
    @(negedge clk); evt = '0; rid = '0; pasid = '0; domid = '0;
  endtask

  task automatic t_reset();
    logic [63:0] d;
    rd(ra(0,0,0), d); chk("R1 count", d, 0);
    rd(ra(1,3,4), d); chk("R1 filter", d, 0);
    rd(ra(0,2,1), d); chk("R1 select", d, 0);
  endtask

  task automatic t_cap();
    logic [63:0] d;
    rd(ra(1,2,7), d); chk("R9 capability", d, 64'h0402);
    wr(ra(0,0,7), 64'hFFFF);
    rd(ra(0,0,7), d); chk("R9 cap write ignored", d, 64'h0402);
  endtask

  task automatic t_select();
    logic [63:0] d;
    wr(ra(0,0,1), 64'h5);
    rd(ra(0,0,1), d); chk("R4 select readback", d, 64'h5);
    repeat (3) pulse(4, 0, 0, 0);
    rd(ra(0,0,0), d); chk("R7 three events", d, 3);
    pulse(0, 0, 0, 0);
    rd(ra(0,0,0), d); chk("R4 other strobe ignored", d, 3);
    wr(ra(0,0,1), 64'h18);
    pulse(23, 0, 0, 0);
    rd(ra(0,0,0), d); chk("R4 code 24", d, 4);
    wr(ra(0,0,1), 64'h19);
    pulse(23, 0, 0, 0); pulse(0, 0, 0, 0);
    rd(ra(0,0,0), d); chk("R4 code 25 inert", d, 4);
    wr(ra(0,0,1), 64'h0);
    pulse(4, 0, 0, 0);
    rd(ra(0,0,0), d); chk("R4 code 0 disabled", d, 4);
  endtask

  task automatic t_filter();
    logic [63:0] d;
    wr(ra(0,1,1), 64'h1);
    wr(ra(0,1,2), 64'h0000_00FF_8000_1234);
    pulse(0, 16'h12AB, 0, 0);
    rd(ra(0,1,0), d); chk("R6 rid masked match", d, 1);
    pulse(0, 16'h1334, 0, 0);
    rd(ra(0,1,0), d); chk("R6 rid mismatch", d, 1);
    wr(ra(0,1,3), 64'h0000_0000_0000_FFFF);
    wr(ra(0,1,4), 64'h0000_0000_8000_0042);
    pulse(0, 16'h1234, 16'h0001, 16'h0042);
    rd(ra(0,1,0), d); chk("R6 all filters match", d, 2);
    pulse(0, 16'h1234, 16'h0001, 16'h0043);
    rd(ra(0,1,0), d); chk("R6 domain mismatch", d, 2);
    wr(ra(1,0,3), 64'hFFFF_FFFF_FFFF_FFFF);
    rd(ra(1,0,3), d); chk("R5 filter layout", d, 64'h0000_FFFF_8000_FFFF);
  endtask

  task automatic t_wrap();
    logic [63:0] d;
    wr(ra(1,1,1), 64'h2);
    wr(ra(1,1,0), 64'hFFFF_FFFF_FFFF_FFFF);
    rd(ra(1,1,0), d); chk("R2 48-bit load", d, 64'h0000_FFFF_FFFF_FFFF);
    pulse(1, 0, 0, 0);
    rd(ra(1,1,0), d); chk("R2 wrap to zero", d, 0);
  endtask

  task automatic t_priority();
    logic [63:0] d;
    wr(ra(1,2,1), 64'h3);
    @(negedge clk); we = 1'b1; addr = ra(1,2,0); wdata = 64'd100; evt = 24'(1) << 2;
    @(negedge clk); we = 1'b0; wdata = '0; evt = '0;
    rd(ra(1,2,0), d); chk("R3 write beats event", d, 100);
    pulse(2, 0, 0, 0);
    rd(ra(1,2,0), d); chk("R3 count after reload", d, 101);
  endtask

  task automatic t_unimpl();
    logic [63:0] d;
    wr(ra(2,0,0), 64'd55);
    rd(ra(2,0,0), d); chk("R8 missing bank reads zero", d, 0);
    rd(ra(0,0,0), d); chk("R8 missing bank write ignored", d, 4);
    wr(ra(0,0,5), 64'hABCD);
    rd(ra(0,0,5), d); chk("R8 missing kind reads zero", d, 0);
    rd(ra(0,0,1), d); chk("R8 missing kind write ignored", d, 0);
  endtask

  task automatic t_indep();
    logic [63:0] d;
    wr(ra(1,3,1), 64'd10);
    pulse(9, 0, 0, 0);
    rd(ra(1,3,0), d); chk("R10 target slot counts", d, 1);
    rd(ra(1,2,0), d); chk("R10 neighbour unchanged", d, 101);
    rd(ra(1,1,0), d); chk("R10 other bank slot unchanged", d, 0);
    rd(ra(0,1,0), d); chk("R10 bank0 slot unchanged", d, 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    t_reset();
    t_cap();
    t_select();
    t_filter();
    t_wrap();
    t_priority();
    t_unimpl();
    t_indep();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CYCLE * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule